// File: doc/BRIEF.md
# Windowed General-Purpose Register File

This block is the integer register file of a processor core that gives each procedure a fresh set of registers without saving anything to memory on a call. Software always names 32 architectural registers with a 5-bit number. Registers 1 to 7 are global: every procedure sees the same storage for them. Register 0 is a constant zero. Registers 8 to 31 are seen through a window that slides over a larger physical array.

A current-window pointer selects where the window sits. A call moves the window up by 16 entries, and a return moves it back down. Consecutive windows overlap by 8 entries, so the values a caller leaves in its top eight registers (24 to 31) appear to the callee as registers 8 to 15. With the default of five windows the array holds 8 global entries and 88 windowed entries. The block provides two combinational read ports and one write port.

When a call is requested in the last window, or a return is requested in the first, the pointer does not move and a one-cycle flag is raised. The surrounding core uses this flag to start a spill or fill sequence. That sequence is not part of this block.

Top module: `wgpr_file`

## Requirements
- R1: Register 0 always reads as zero on both read ports, and a write addressed to register 0 changes no stored value.
- R2: Registers 1 to 7 use one physical entry each, independent of the window pointer. A value written in any window reads back unchanged in every other window.
- R3: Register r in the range 8 to 31 uses windowed entry cwp*16 + (r - 8). As a result, caller registers 24 to 31 are the same storage as registers 8 to 15 after one advance.
- R4: `win_adv` alone with `cwp_o` below NUM_WIN-1 makes `cwp_o` one higher on the next cycle. `win_ret` alone with `cwp_o` above 0 makes it one lower.
- R5: `win_adv` alone with `cwp_o` equal to NUM_WIN-1 leaves `cwp_o` unchanged and raises `ovf_o` for exactly the next cycle.
- R6: `win_ret` alone with `cwp_o` equal to 0 leaves `cwp_o` unchanged and raises `unf_o` for exactly the next cycle.
- R7: `win_adv` and `win_ret` together are ignored. `cwp_o` stays, and neither flag is raised.
- R8: A read of the register being written in the same cycle returns `wr_data` (bypass). Register 0 is excluded and still reads zero.
- R9: Synchronous active-low reset sets `cwp_o` to 0, clears both flags and clears every stored register to zero.
- R10: A write in a cycle where the window also moves lands in the window selected by the pointer before the move.
- R11: Registers 16 to 23 of a window are private to it. A write there is invisible to any other window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd0_addr | input | 5 | Architectural register number, read port 0 |
| rd0_data | output | DATA_W | Read data, port 0 (combinational) |
| rd1_addr | input | 5 | Architectural register number, read port 1 |
| rd1_data | output | DATA_W | Read data, port 1 (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural register number for the write |
| wr_data | input | DATA_W | Write data |
| win_adv | input | 1 | Advance the window (procedure call) |
| win_ret | input | 1 | Retreat the window (procedure return) |
| cwp_o | output | $clog2(NUM_WIN) | Current window pointer |
| ovf_o | output | 1 | One-cycle pulse after a refused advance |
| unf_o | output | 1 | One-cycle pulse after a refused retreat |

## Verification
The hardest case to reach from the ports is a window move combined with a write and a later check of where that write landed. The value is only visible after the pointer has moved back, and only through the overlap or private ranges of a different window. The directed stimulus walks the pointer to the top and then to the bottom. On the way it writes overlap and private registers in the same cycle as a move, and then retreats to read them back. Refused moves at both ends and simultaneous advance and retreat are also placed in the directed sequence. A long random phase then mixes moves, writes and same-cycle bypass reads, and each cycle is compared with a behavioural model.

// File: rtl/wgpr_pkg.sv
// Package: architectural constants shared by the windowed register file.
// Assumes a 32-entry architectural space with 8 globals and a 16-entry
// window stride (24 visible windowed registers, 8 of them overlapping).
package wgpr_pkg;
    localparam int ARCH_REGS   = 32;
    localparam int AREG_W      = 5;
    localparam int GLOBAL_REGS = 8;
    localparam int WIN_STRIDE  = 16;
    localparam int WIN_SPAN    = ARCH_REGS - GLOBAL_REGS;
    typedef logic [AREG_W-1:0] areg_t;
endpackage

// File: rtl/wgpr_ptr.sv
// Module: window pointer control.
// Moves the pointer on a lone advance or retreat request, refuses moves
// past either end and reports a refused move with a one-cycle flag.
// Assumes NUM_WIN >= 2. A simultaneous advance and retreat is ignored.
module wgpr_ptr #(
    parameter int NUM_WIN = 5,
    parameter int PTR_W   = $clog2(NUM_WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             ret,
    output logic [PTR_W-1:0] cwp,
    output logic             ovf,
    output logic             unf
);
    localparam logic [PTR_W-1:0] TOP = PTR_W'(NUM_WIN - 1);

    logic adv_only, ret_only, at_top, at_bot;

    // Decode lone requests and the end positions.
    always_comb begin
        adv_only = adv && !ret;
        ret_only = ret && !adv;
        at_top   = (cwp == TOP);
        at_bot   = (cwp == '0);
    end

    // Pointer update and refused-move flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp <= '0;
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            ovf <= adv_only && at_top;
            unf <= ret_only && at_bot;
            if (adv_only && !at_top)
                cwp <= cwp + 1'b1;
            else if (ret_only && !at_bot)
                cwp <= cwp - 1'b1;
        end
    end
endmodule

// File: rtl/wgpr_map.sv
// Module: architectural-to-physical register index translation.
// Globals (r0..r7) map to physical entries 0..7. A windowed register r maps
// to 8 + cwp*16 + (r-8), which simplifies to r + cwp*16.
// Assumes IDX_W is wide enough for the highest index.
module wgpr_map
    import wgpr_pkg::*;
#(
    parameter int PTR_W = 3,
    parameter int IDX_W = 7
) (
    input  areg_t             areg,
    input  logic [PTR_W-1:0]  cwp,
    output logic [IDX_W-1:0]  idx,
    output logic              is_zero
);
    localparam int SHIFT = $clog2(WIN_STRIDE);

    // Select the global or windowed index.
    always_comb begin
        is_zero = (areg == '0);
        if (int'(areg) < GLOBAL_REGS)
            idx = IDX_W'(areg);
        else
            idx = IDX_W'(areg) + (IDX_W'(cwp) << SHIFT);
    end
endmodule

// File: rtl/wgpr_array.sv
// Module: physical register storage, one write port and two read ports.
// Entry 0 is never written. It backs r0, which the top forces to zero.
// Reset clears all entries synchronously. Reads are combinational.
module wgpr_array #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 96,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx0,
    input  logic [IDX_W-1:0]  ridx1,
    output logic [DATA_W-1:0] rdata0,
    output logic [DATA_W-1:0] rdata1
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Storage update: clear on reset, otherwise the single write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (we && widx != '0) begin
            mem[widx] <= wdata;
        end
    end

    // Combinational read of both ports.
    always_comb begin
        rdata0 = mem[ridx0];
        rdata1 = mem[ridx1];
    end
endmodule

// File: rtl/wgpr_file.sv
// Module: windowed general-purpose register file (top).
// Translates three architectural numbers through the current window,
// forwards same-cycle write data to the readers and forces r0 to zero.
// Assumes one write per cycle. A write in a cycle where the window moves
// uses the pointer value from before the move.
module wgpr_file
    import wgpr_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int NUM_WIN = 5,
    parameter int PTR_W   = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        rd0_addr,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [4:0]        rd1_addr,
    output logic [DATA_W-1:0] rd1_data,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              win_adv,
    input  logic              win_ret,
    output logic [PTR_W-1:0]  cwp_o,
    output logic              ovf_o,
    output logic              unf_o
);
    localparam int DEPTH = GLOBAL_REGS + (NUM_WIN - 1) * WIN_STRIDE + WIN_SPAN;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int NPORT = 3;   // 0: read 0, 1: read 1, 2: write

    logic [PTR_W-1:0]  cwp;
    logic [IDX_W-1:0]  pidx  [NPORT];
    logic              pzero [NPORT];
    areg_t             aregs [NPORT];
    logic [DATA_W-1:0] raw0, raw1;
    logic              we_eff;

    // Gather architectural numbers for the translators.
    always_comb begin
        aregs[0] = rd0_addr;
        aregs[1] = rd1_addr;
        aregs[2] = wr_addr;
    end

    wgpr_ptr #(.NUM_WIN(NUM_WIN), .PTR_W(PTR_W)) u_ptr (
        .clk (clk),
        .rst_n (rst_n),
        .adv (win_adv),
        .ret (win_ret),
        .cwp (cwp),
        .ovf (ovf_o),
        .unf (unf_o)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        wgpr_map #(.PTR_W(PTR_W), .IDX_W(IDX_W)) u_map (
            .areg    (aregs[p]),
            .cwp     (cwp),
            .idx     (pidx[p]),
            .is_zero (pzero[p])
        );
    end

    // Drop writes to r0 before they reach storage.
    always_comb we_eff = wr_en && !pzero[2];

    wgpr_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we_eff),
        .widx   (pidx[2]),
        .wdata  (wr_data),
        .ridx0  (pidx[0]),
        .ridx1  (pidx[1]),
        .rdata0 (raw0),
        .rdata1 (raw1)
    );

    // Read result: zero for r0, forwarded write data on a hit, else storage.
    always_comb begin
        if (pzero[0])                          rd0_data = '0;
        else if (we_eff && pidx[0] == pidx[2]) rd0_data = wr_data;
        else                                   rd0_data = raw0;
        if (pzero[1])                          rd1_data = '0;
        else if (we_eff && pidx[1] == pidx[2]) rd1_data = wr_data;
        else                                   rd1_data = raw1;
        cwp_o = cwp;
    end
endmodule

// File: rtl/wgpr_file_chk.sv
// Module: assertion checker for wgpr_file, attached with bind below.
module wgpr_file_chk #(
    parameter int DATA_W  = 64,
    parameter int NUM_WIN = 5,
    parameter int PTR_W   = $clog2(NUM_WIN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        rd0_addr,
    input logic [DATA_W-1:0] rd0_data,
    input logic [4:0]        rd1_addr,
    input logic [DATA_W-1:0] rd1_data,
    input logic              wr_en,
    input logic [4:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              win_adv,
    input logic              win_ret,
    input logic [PTR_W-1:0]  cwp_o,
    input logic              ovf_o,
    input logic              unf_o
);
    localparam logic [PTR_W-1:0] TOP = PTR_W'(NUM_WIN - 1);

    // R1
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_addr == 5'd0) |-> (rd0_data == '0 && (rd1_addr != 5'd0 || rd1_data == '0)));

    // R4
    adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_adv && !win_ret && cwp_o != TOP) |=> (cwp_o == PTR_W'($past(cwp_o) + 1'b1)));

    // R4
    ret_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_ret && !win_adv && cwp_o != '0) |=> (cwp_o == PTR_W'($past(cwp_o) - 1'b1)));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_adv && !win_ret && cwp_o == TOP) |=> (ovf_o && $stable(cwp_o)));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_ret && !win_adv && cwp_o == '0) |=> (unf_o && $stable(cwp_o)));

    // R7
    both_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_adv && win_ret) |=> ($stable(cwp_o) && !ovf_o && !unf_o));

    // R8
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 5'd0 && rd1_addr == wr_addr) |-> (rd1_data == wr_data));

    // R4
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cwp_o <= TOP) && !(ovf_o && unf_o));
endmodule

bind wgpr_file wgpr_file_chk #(.DATA_W(DATA_W), .NUM_WIN(NUM_WIN), .PTR_W(PTR_W)) u_chk (
    .clk (clk), .rst_n (rst_n),
    .rd0_addr (rd0_addr), .rd0_data (rd0_data),
    .rd1_addr (rd1_addr), .rd1_data (rd1_data),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .win_adv (win_adv), .win_ret (win_ret),
    .cwp_o (cwp_o), .ovf_o (ovf_o), .unf_o (unf_o)
);

// File: tb/wgpr_file_bench.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks for window moves, overlap, privacy and refused moves.
module wgpr_file_bench;
    localparam int DW    = 64;
    localparam int NW    = 5;
    localparam int PW    = $clog2(NW);
    localparam int NPHYS = 8 + (NW - 1) * 16 + 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    rd0_addr = '0, rd1_addr = '0, wr_addr = '0;
    logic [DW-1:0] rd0_data, rd1_data, wr_data = '0;
    logic          wr_en = 1'b0, win_adv = 1'b0, win_ret = 1'b0;
    logic [PW-1:0] cwp_o;
    logic          ovf_o, unf_o;

    always #5 clk = ~clk;

    wgpr_file #(.DATA_W(DW), .NUM_WIN(NW)) u_wgpr_file (
        .clk(clk), .rst_n(rst_n),
        .rd0_addr(rd0_addr), .rd0_data(rd0_data),
        .rd1_addr(rd1_addr), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .win_adv(win_adv), .win_ret(win_ret),
        .cwp_o(cwp_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    // Reference model state
    logic [DW-1:0] mdl [NPHYS];
    int            m_cwp;
    bit            m_ovf, m_unf;
    int            checks = 0, failures = 0;
    bit            done = 0;

    function automatic int pidx(int r, int w);
        return (r < 8) ? r : 8 + w * 16 + (r - 8);
    endfunction

    function automatic logic [DW-1:0] exp_rd(int a);
        if (a == 0) return '0;
        if (wr_en && int'(wr_addr) == a) return wr_data;
        return mdl[pidx(a, m_cwp)];
    endfunction

    function automatic string rd_tag(int a);
        if (a == 0) return "R1";
        if (wr_en && int'(wr_addr) == a) return "R8";
        if (a < 8) return "R2";
        return "R3";
    endfunction

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NPHYS; i++) mdl[i] = '0;
        m_cwp = 0; m_ovf = 0; m_unf = 0;
    endtask

    // Apply one cycle: compare at negedge+1, clock, update model.
    task automatic drive(bit adv, bit ret, bit we, int wa, logic [DW-1:0] wd, int ra0, int ra1);
        bit ao, ro;
        win_adv = adv; win_ret = ret; wr_en = we;
        wr_addr = 5'(wa); wr_data = wd;
        rd0_addr = 5'(ra0); rd1_addr = 5'(ra1);
        #1;
        chk(rd_tag(ra0), rd0_data, exp_rd(ra0));
        chk(rd_tag(ra1), rd1_data, exp_rd(ra1));
        chk("R4", DW'(cwp_o), DW'(m_cwp));
        chk("R5", DW'(ovf_o), DW'(m_ovf));
        chk("R6", DW'(unf_o), DW'(m_unf));
        @(posedge clk);
        if (we && wa != 0) mdl[pidx(wa, m_cwp)] = wd;
        ao = adv && !ret; ro = ret && !adv;
        m_ovf = ao && (m_cwp == NW - 1);
        m_unf = ro && (m_cwp == 0);
        if (ao && m_cwp < NW - 1) m_cwp++;
        else if (ro && m_cwp > 0) m_cwp--;
        @(negedge clk);
    endtask

    task automatic idle(); drive(0, 0, 0, 0, '0, 0, 0); endtask

    // Read one register on port 0 with no write, sampled after settling.
    task automatic peek(int a, output logic [DW-1:0] v);
        win_adv = 0; win_ret = 0; wr_en = 0; rd0_addr = 5'(a);
        #1; v = rd0_data;
    endtask

    initial begin
        logic [DW-1:0] v;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        peek(13, v); chk("R9 reg", v, '0);
        chk("R9 cwp", DW'(cwp_o), '0);
        chk("R9 flags", DW'({ovf_o, unf_o}), '0);
        idle();
        // R1: write to r0 ignored
        drive(0, 0, 1, 0, 64'hDEAD_BEEF, 0, 0);
        peek(0, v); chk("R1 r0", v, '0);
        // R2: global written in window 0, seen in window 1
        drive(0, 0, 1, 3, 64'hA5A5_0003, 3, 0);
        drive(1, 0, 1, 26, 64'h1111_0026, 26, 3);   // r26 in window 0, then advance
        peek(3, v); chk("R2 global", v, 64'hA5A5_0003);
        // R3: window 0 r26 is window 1 r10
        peek(10, v); chk("R3 overlap", v, 64'h1111_0026);
        // R11: private r17 written in window 1
        drive(0, 0, 1, 17, 64'h2222_0017, 17, 0);
        // R10: write r20 in window 1 while advancing
        drive(1, 0, 1, 20, 64'h3333_0020, 20, 0);
        peek(17, v); chk("R11 private", v, '0);
        peek(20, v); chk("R10 new win", v, '0);
        drive(0, 1, 0, 0, '0, 0, 0);
        peek(20, v); chk("R10 old win", v, 64'h3333_0020);
        peek(17, v); chk("R11 own", v, 64'h2222_0017);
        // R8: bypass on both ports
        drive(0, 0, 1, 21, 64'h4444_0021, 21, 21);
        // climb to top, then R5
        while (m_cwp < NW - 1) drive(1, 0, 0, 0, '0, 9, 30);
        drive(1, 0, 0, 0, '0, 0, 0);
        chk("R5 ovf", DW'(ovf_o), 1);
        chk("R5 cwp", DW'(cwp_o), DW'(NW - 1));
        idle();
        chk("R5 pulse", DW'(ovf_o), 0);
        // R7: both requests together
        drive(1, 1, 0, 0, '0, 0, 0);
        chk("R7 cwp", DW'(cwp_o), DW'(NW - 1));
        chk("R7 flags", DW'({ovf_o, unf_o}), 0);
        // descend to bottom, then R6
        while (m_cwp > 0) drive(0, 1, 0, 0, '0, 24, 15);
        drive(0, 1, 0, 0, '0, 0, 0);
        chk("R6 unf", DW'(unf_o), 1);
        chk("R6 cwp", DW'(cwp_o), 0);
        // random phase
        for (int n = 0; n < 4000; n++) begin
            int ra0, wa;
            wa  = int'($urandom_range(0, 31));
            ra0 = ($urandom_range(0, 3) == 0) ? wa : int'($urandom_range(0, 31));
            drive($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
                  $urandom_range(0, 1) == 1, wa, {$urandom, $urandom},
                  ra0, int'($urandom_range(0, 31)));
        end
        idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(10 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule